// File: doc/BRIEF.md
# Table-Driven Serial Convolutional Encoder

This block is a rate-1/N convolutional encoder. Each input symbol is K bits wide. The encoder produces the N code bits for one trellis step on a single serial line, one bit per clock. The sliding window has MEM symbol positions: the symbol currently applied, followed by the MEM-1 symbols taken before it. The N generator polynomials are inputs that can change at run time. The block does not evaluate the XOR network for every bit. Instead it holds two tables, both addressed by the window: one gives the N code bits and the other gives the next state. The tables are filled in a single cycle after reset, and again whenever any polynomial differs from the copy the block last captured.

The control is a two-state machine. **FILL** loads both tables and captures the polynomials. **SHIFT** runs a divider that counts N phases per symbol. The transitions are:
- **reset → FILL**.
- **FILL → SHIFT** (unconditional).
- **SHIFT → SHIFT** (polynomials unchanged). The phase counts up and wraps after N-1. On the wrap the state register takes the table's next-state value.
- **SHIFT → FILL** (polynomials changed). The step is abandoned, the state is kept and the phase returns to 0.

In every cycle that is not a step the serial output is forced low. The user holds each symbol stable for the N clocks of its step. Steps start at the first clock after a FILL cycle and follow each other back to back.

Top module: `conv_lut_encoder`

## Requirements
- R1: The code bit for polynomial j is the XOR reduction of that polynomial ANDed with the window. The window is {current symbol, previous MEM-1 symbols}, newest at the MSB, so the polynomial MSB weights the newest bit and its LSB the oldest. Polynomial j occupies `gen_poly[j*MEM*K_IN +: MEM*K_IN]`.
- R2: Within one step the serial output presents the code bit of polynomial 0 first, then polynomial 1, and so on. Each bit is registered and appears after the rising edge of its own phase, at one bit per clock.
- R3: The window moves forward by one symbol only at the edge that emits the last (N-th) bit of a step. At every other edge the stored state is unchanged, so the symbol must be held for N clocks.
- R4: A synchronous active-high `rst` clears the serial output, the phase and the stored state to 0. The first edge after `rst` falls is a FILL cycle with output 0, and the first step starts at the next edge.
- R5: A change in any polynomial while in SHIFT produces two cycles with output 0: the detecting edge, then FILL. The stored state is kept, and the next step starts with the new polynomials.
- R6: With N=2, K_IN=1, MEM=4, polynomial 0 = 1111 and polynomial 1 = 1101, the symbols 1,0,1,1 followed by zeros give the serial sequence 11110111010111.
- R7: An all-zero window produces 0 output bits. The output is therefore 0 before data arrives and returns to 0 once MEM-1 zero symbols have followed the last data symbol.
- R8: For any polynomials and any symbol stream, the serial output equals a direct shift-register XOR model of R1 to R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; also the serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | K_IN | Input symbol, held for N_OUT clocks per step |
| gen_poly | input | N_OUT*MEM*K_IN | Generator polynomials packed side by side, polynomial 0 in the low bits |
| ser_out | output | 1 | Serial code bit stream |

## Verification
The assertions assume that the polynomials change only at a step boundary and that the symbol stays constant across the N phases of a step. The properties on stored state and quiet cycles depend on both. The stimulus drives every input at the falling clock edge that ends a step. It changes the polynomials only at those points, always to a value that differs from the previous one. It applies the mid-stream reset at a step boundary too, so each check lands on a known phase.

// File: rtl/clu_pkg.sv
package clu_pkg;
    // Control modes of the encoder sequencer
    typedef enum logic {
        CLU_FILL  = 1'b0,
        CLU_SHIFT = 1'b1
    } clu_mode_e;
endpackage

// File: rtl/clu_ctrl.sv
module clu_ctrl
    import clu_pkg::*;
#(
    parameter int N_OUT = 2,
    parameter int PW    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_OUT*PW-1:0]           poly_in,
    output clu_mode_e                     mode,
    output logic [((N_OUT>1)?$clog2(N_OUT):1)-1:0] phase,
    output logic                          load,
    output logic                          emit,
    output logic                          step_end
);
    localparam int CW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(N_OUT - 1);

    clu_mode_e              mode_nx;
    logic [N_OUT*PW-1:0]    poly_q;
    logic                   poly_chg;

    assign poly_chg = (poly_in != poly_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) mode <= CLU_FILL;
        else     mode <= mode_nx;
    end

    // transitions
    always_comb begin
        unique case (mode)
            CLU_FILL:  mode_nx = CLU_SHIFT;
            CLU_SHIFT: mode_nx = poly_chg ? CLU_FILL : CLU_SHIFT;
            default:   mode_nx = CLU_FILL;
        endcase
    end

    // divider and captured polynomials
    always_ff @(posedge clk) begin
        if (rst) begin
            poly_q <= '0;
            phase  <= '0;
        end else begin
            unique case (mode)
                CLU_FILL: begin
                    poly_q <= poly_in;
                    phase  <= '0;
                end
                CLU_SHIFT: begin
                    if (poly_chg || phase == LAST) phase <= '0;
                    else                           phase <= phase + 1'b1;
                end
                default: phase <= '0;
            endcase
        end
    end

    assign load     = (mode == CLU_FILL);
    assign emit     = (mode == CLU_SHIFT) && !poly_chg;
    assign step_end = emit && (phase == LAST);
endmodule

// File: rtl/clu_tables.sv
module clu_tables #(
    parameter int N_OUT = 2,
    parameter int K_IN  = 1,
    parameter int MEM   = 4
) (
    input  logic                      clk,
    input  logic                      load,
    input  logic [N_OUT*MEM*K_IN-1:0] poly_in,
    input  logic [MEM*K_IN-1:0]       rd_idx,
    output logic [N_OUT-1:0]          rd_code,
    output logic [(MEM-1)*K_IN-1:0]   rd_next
);
    localparam int WIN   = MEM * K_IN;
    localparam int SW    = (MEM - 1) * K_IN;
    localparam int DEPTH = 1 << WIN;

    logic [WIN-1:0]   poly_v   [N_OUT];
    logic [N_OUT-1:0] code_tab [DEPTH];
    logic [SW-1:0]    nxt_tab  [DEPTH];

    for (genvar j = 0; j < N_OUT; j++) begin : g_poly
        assign poly_v[j] = poly_in[j*WIN +: WIN];
    end

    function automatic logic [N_OUT-1:0] code_of(input int a);
        logic [WIN-1:0]   w;
        logic [N_OUT-1:0] c;
        w = WIN'(a);
        for (int j = 0; j < N_OUT; j++) c[j] = ^(poly_v[j] & w);
        return c;
    endfunction

    function automatic logic [SW-1:0] next_of(input int a);
        logic [WIN-1:0] w;
        w = WIN'(a);
        return w[WIN-1 -: SW];   // drop the oldest symbol
    endfunction

    always_ff @(posedge clk) begin
        if (load) begin
            for (int a = 0; a < DEPTH; a++) begin
                code_tab[a] <= code_of(a);
                nxt_tab[a]  <= next_of(a);
            end
        end
    end

    assign rd_code = code_tab[rd_idx];
    assign rd_next = nxt_tab[rd_idx];
endmodule

// File: rtl/clu_shift.sv
module clu_shift #(
    parameter int N_OUT = 2,
    parameter int SW    = 3
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   emit,
    input  logic                                   step_end,
    input  logic [((N_OUT>1)?$clog2(N_OUT):1)-1:0] phase,
    input  logic [N_OUT-1:0]                       code,
    input  logic [SW-1:0]                          nxt,
    output logic [SW-1:0]                          state_q,
    output logic                                   ser_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            ser_out <= 1'b0;
        end else begin
            ser_out <= emit ? code[phase] : 1'b0;
            if (step_end) state_q <= nxt;
        end
    end
endmodule

// File: rtl/conv_lut_encoder.sv
module conv_lut_encoder
    import clu_pkg::*;
#(
    parameter int N_OUT = 2,
    parameter int K_IN  = 1,
    parameter int MEM   = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [K_IN-1:0]           sym_in,
    input  logic [N_OUT*MEM*K_IN-1:0] gen_poly,
    output logic                      ser_out
);
    localparam int WIN = MEM * K_IN;
    localparam int SW  = (MEM - 1) * K_IN;
    localparam int CW  = (N_OUT > 1) ? $clog2(N_OUT) : 1;

    clu_mode_e        mode;
    logic [CW-1:0]    phase;
    logic             load, emit, step_end;
    logic [SW-1:0]    state_q;
    logic [SW-1:0]    nxt;
    logic [N_OUT-1:0] code;
    logic [WIN-1:0]   rd_idx;

    assign rd_idx = {sym_in, state_q};

    clu_ctrl #(.N_OUT(N_OUT), .PW(WIN)) u_ctrl (
        .clk(clk), .rst(rst), .poly_in(gen_poly), .mode(mode), .phase(phase),
        .load(load), .emit(emit), .step_end(step_end)
    );

    clu_tables #(.N_OUT(N_OUT), .K_IN(K_IN), .MEM(MEM)) u_tables (
        .clk(clk), .load(load), .poly_in(gen_poly), .rd_idx(rd_idx),
        .rd_code(code), .rd_next(nxt)
    );

    clu_shift #(.N_OUT(N_OUT), .SW(SW)) u_shift (
        .clk(clk), .rst(rst), .emit(emit), .step_end(step_end), .phase(phase),
        .code(code), .nxt(nxt), .state_q(state_q), .ser_out(ser_out)
    );
endmodule

// File: rtl/clu_checks.sv
module clu_checks
    import clu_pkg::*;
#(
    parameter int N_OUT = 2,
    parameter int K_IN  = 1,
    parameter int MEM   = 4
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic [K_IN-1:0]                        sym_in,
    input logic [N_OUT*MEM*K_IN-1:0]              gen_poly,
    input logic                                   ser_out,
    input clu_mode_e                              mode,
    input logic [((N_OUT>1)?$clog2(N_OUT):1)-1:0] phase,
    input logic [(MEM-1)*K_IN-1:0]                state_q
);
    localparam int CW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(N_OUT - 1);

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);

    assert_reset_clear_R4: assert property (@(posedge clk)
        rst |=> (!ser_out && phase == '0 && state_q == '0));

    assert_fill_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == CLU_FILL) |=> !ser_out);

    assert_state_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> $stable(state_q));

    assert_poly_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (gen_poly != $past(gen_poly)) |=> !ser_out);

    assert_poly_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (gen_poly != $past(gen_poly)) |=> $stable(state_q));

    assert_zero_window_R7: assert property (@(posedge clk) disable iff (rst)
        (sym_in == '0 && state_q == '0) |=> !ser_out);
endmodule

bind conv_lut_encoder clu_checks #(.N_OUT(N_OUT), .K_IN(K_IN), .MEM(MEM)) u_checks (
    .clk(clk), .rst(rst), .sym_in(sym_in), .gen_poly(gen_poly), .ser_out(ser_out),
    .mode(mode), .phase(phase), .state_q(state_q)
);

// File: tb/conv_lut_encoder_bench.sv
module conv_lut_encoder_bench;
    localparam int N   = 2;
    localparam int K   = 1;
    localparam int M   = 4;
    localparam int WIN = M * K;
    localparam int SW  = (M - 1) * K;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [K-1:0]      sym_in = '0;
    logic [N*WIN-1:0]  gen_poly = '0;
    logic              ser_out;

    int          checks = 0;
    int          fails  = 0;
    int          cyc    = 0;
    logic [SW-1:0] hist = '0;

    always #10 clk = ~clk;   // 50 MHz

    conv_lut_encoder #(.N_OUT(N), .K_IN(K), .MEM(M)) u_conv_lut_encoder (
        .clk(clk), .rst(rst), .sym_in(sym_in), .gen_poly(gen_poly), .ser_out(ser_out)
    );

    // {symbol, first emitted bit, second emitted bit}
    localparam logic [2:0] GOLD [7] = '{3'b1_11, 3'b0_11, 3'b1_01, 3'b1_11,
                                        3'b0_01, 3'b0_01, 3'b0_11};

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 20000) begin
            fails++;
            $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
            summary();
            $finish;
        end
    end

    function automatic logic [N-1:0] ref_code(input logic [K-1:0] s);
        logic [WIN-1:0] w;
        logic [N-1:0]   c;
        w = {s, hist};
        for (int j = 0; j < N; j++) c[j] = ^(gen_poly[j*WIN +: WIN] & w);
        return c;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: ser_out=%b expected %b", tag, got, exp);
        end
    endtask

    // called at a falling edge on a step boundary
    task automatic run_step(input logic [K-1:0] s, input logic [N-1:0] exp, input string tag);
        logic [WIN-1:0] w;
        sym_in = s;
        for (int j = 0; j < N; j++) begin
            @(posedge clk); @(negedge clk);
            chk(ser_out, exp[j], tag);
        end
        w = {s, hist};
        hist = w[WIN-1 -: SW];
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            chk(ser_out, 1'b0, tag);
        end
    endtask

    initial begin
        logic [N*WIN-1:0] np;
        gen_poly = {4'b1101, 4'b1111};
        repeat (3) @(negedge clk);
        chk(ser_out, 1'b0, "R4 output during reset");
        rst = 1'b0;
        quiet(1, "R4 fill cycle after reset");

        // golden vector: R6, with R1 R2 R3 ordering and stepping
        for (int i = 0; i < 7; i++)
            run_step(GOLD[i][2], {GOLD[i][0], GOLD[i][1]}, "R6 R1 R2 R3 golden");

        // flush tail stays low
        for (int i = 0; i < 3; i++) run_step('0, '0, "R7 zero window");

        // random polynomials and streams against the reference model
        for (int r = 0; r < 6; r++) begin
            np = N*WIN'($urandom);
            if (np == gen_poly) np = ~gen_poly;
            gen_poly = np;
            quiet(2, "R5 polynomial reload quiet");
            for (int i = 0; i < 20; i++) begin
                logic [K-1:0] s;
                s = K'($urandom);
                run_step(s, ref_code(s), "R8 R1 random stream");
            end
        end

        // mid-stream reset at a step boundary
        run_step('1, ref_code('1), "R8 before reset");
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(ser_out, 1'b0, "R4 mid-stream reset");
        rst = 1'b0;
        hist = '0;
        quiet(1, "R4 fill after mid-stream reset");
        run_step('1, ref_code('1), "R4 state cleared by reset");
        run_step('0, ref_code('0), "R4 state cleared by reset");

        summary();
        $finish;
    end
endmodule